// File: doc/BRIEF.md
# Expansion Slot ROM Window Decoder

This block decodes the upper part of a 16-bit address space for an 8-bit processor system. In the 0xC100–0xCFFF peripheral area it chooses one of three ROM sources for each access. The first is a 256-byte ROM page belonging to one expansion card. The second is a 2 KB expansion window that several cards share. The third is the internal system ROM. It also maps the upper system ROM, which ends at 0xFFFF, into one of up to four banks. Any read that no device backs returns a fixed floating-bus byte.

The expansion window belongs to one card at a time. The owner is held in a register. Any access to a card's own page makes that card the owner. An access to 0xCFFF gives up ownership. Two soft-switch levels can override card ROM with internal ROM: one does so for the whole peripheral area, the other for slot 3 only. The ROM arrays sit outside the block. The decoder reports a source code, a slot index and a local byte offset. It then muxes the byte that the selected ROM returns onto its read-data output.

Top module: `slot_rom_window_dec`

## Requirements
- R1: An access to 0xC100–0xC7FF is decoded as slot number addr[10:8] with offset addr[7:0]. With no override active and that slot's page ROM present, the source code is 1 (card page) and rd_data is the card page byte.
- R2: Any read or write in 0xC100–0xC7FF while int_rom_en is low makes addr[10:8] the window owner from the next clock edge. Write data never reaches any ROM.
- R3: A read in 0xC800–0xCFFF is served by the owner's expansion ROM. The source code is 2, the offset is addr[10:0] and slot_idx equals the owner. This requires a non-zero owner whose expansion ROM is present.
- R4: Any access to 0xCFFF while int_rom_en is low clears the owner to 0 from the next edge. The access itself still uses the previous owner. Owner 0 means no card, so the window reads as unmapped.
- R5: While int_rom_en is high, all of 0xC100–0xCFFF is served from system ROM (source code 3), and the owner does not change. If the system ROM does not cover 0xC000, these reads are unmapped instead.
- R6: While slot3_en is low, the 0xC3xx page is served from system ROM (source code 3). So is the expansion window while slot 3 is the owner.
- R7: System ROM is SYS_ROM_KB kilobytes (16 or 12) and ends at 0xFFFF. Its offset is bank_sel*ROM_BYTES + (addr - (0x10000 - ROM_BYTES)). Addresses 0xD000–0xFFFF always decode to it.
- R8: Unmapped reads return 0xF4 with source code 0. Unmapped addresses are those below 0xC100, a slot whose page or expansion ROM is absent, and owner 0 in the window.
- R9: When rd is low, rd_data is 0xF4. A write therefore produces no data, but it still moves ownership as in R2 and R4.
- R10: After reset the owner is 0, so a window read is unmapped until some slot page is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| int_rom_en | input | 1 | Internal ROM over the whole peripheral area |
| slot3_en | input | 1 | Slot 3 card ROM enabled (low gives internal ROM) |
| bank_sel | input | BANK_W | System ROM bank |
| page_present | input | 8 | Per-slot 256-byte page ROM fitted |
| exp_present | input | 8 | Per-slot 2 KB expansion ROM fitted |
| card_page_data | input | 8 | Byte from the selected card page ROM |
| card_exp_data | input | 8 | Byte from the selected expansion ROM |
| sys_rom_data | input | 8 | Byte from system ROM |
| src | output | 3 | 0 none, 1 card page, 2 card expansion, 3 system ROM |
| slot_idx | output | 3 | Slot whose ROM is addressed |
| rom_offset | output | 16 | Byte offset within the selected ROM |
| rd_data | output | 8 | Read data |

## Verification
The bench walks every combination of the two switches and four banks over all slot pages, window addresses and release accesses. It checks ownership both after reads and after writes. Two specific faults are targeted: a window that uses the new owner in the release cycle (R4), and a slot-3 override that forgets the window when slot 3 owns it (R6). Either shows up as a wrong source code or byte. Slots with page ROM or expansion ROM missing must read 0xF4. A decoder that trusted the ownership alone would return card data there instead.

// File: rtl/slot_rom_window_dec.sv
module slot_rom_window_dec #(
  parameter int SYS_ROM_KB = 16,
  parameter int BANK_W = 2,
  parameter logic [7:0] FLOAT_BYTE = 8'hF4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              int_rom_en,
  input  logic              slot3_en,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [7:0]        page_present,
  input  logic [7:0]        exp_present,
  input  logic [7:0]        card_page_data,
  input  logic [7:0]        card_exp_data,
  input  logic [7:0]        sys_rom_data,
  output logic [2:0]        src,
  output logic [2:0]        slot_idx,
  output logic [15:0]       rom_offset,
  output logic [7:0]        rd_data
);
  localparam logic [2:0] SRC_NONE = 3'd0;
  localparam logic [2:0] SRC_PAGE = 3'd1;
  localparam logic [2:0] SRC_EXP  = 3'd2;
  localparam logic [2:0] SRC_SYS  = 3'd3;
  localparam int ROM_BYTES = SYS_ROM_KB * 1024;
  localparam int ROM_BASE  = 32'h10000 - ROM_BYTES;
  localparam bit C_ROM     = ROM_BASE <= 32'hC000;

  logic [2:0] owner_q;
  wire        acc       = rd | wr;
  wire        in_c      = addr[15:12] == 4'hC;
  wire        in_slot   = in_c && addr[11:8] != 4'h0 && !addr[11];
  wire        in_win    = in_c && addr[11];
  wire        in_hi     = addr[15:12] >= 4'hD;
  wire        release_a = addr == 16'hCFFF;
  wire [2:0]  pslot     = addr[10:8];
  wire [31:0] sys_off32 = 32'(bank_sel) * ROM_BYTES + 32'(addr) - ROM_BASE;

  always_ff @(posedge clk) begin
    if (!rst_n)
      owner_q <= 3'd0;
    else if (acc && !int_rom_en) begin
      if (in_slot)
        owner_q <= pslot;
      else if (release_a)
        owner_q <= 3'd0;
    end
  end

  always_comb begin
    src = SRC_NONE;
    slot_idx = 3'd0;
    rom_offset = 16'd0;
    if (in_hi || ((in_slot || in_win) && C_ROM &&
        (int_rom_en || (!slot3_en && ((in_slot && pslot == 3'd3) ||
                                      (in_win && owner_q == 3'd3)))))) begin
      src = SRC_SYS;
      rom_offset = sys_off32[15:0];
    end else if (in_slot && !int_rom_en && !(pslot == 3'd3 && !slot3_en)) begin
      if (page_present[pslot]) begin
        src = SRC_PAGE;
        slot_idx = pslot;
        rom_offset = {8'd0, addr[7:0]};
      end
    end else if (in_win && !int_rom_en && !(owner_q == 3'd3 && !slot3_en)) begin
      if (owner_q != 3'd0 && exp_present[owner_q]) begin
        src = SRC_EXP;
        slot_idx = owner_q;
        rom_offset = {5'd0, addr[10:0]};
      end
    end
  end

  always_comb begin
    rd_data = FLOAT_BYTE;
    if (rd) begin
      case (src)
        SRC_PAGE: rd_data = card_page_data;
        SRC_EXP:  rd_data = card_exp_data;
        SRC_SYS:  rd_data = sys_rom_data;
        default:  rd_data = FLOAT_BYTE;
      endcase
    end
  end

  assert_owner_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !int_rom_en && in_slot) |=> owner_q == $past(addr[10:8]));
  assert_owner_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !int_rom_en && release_a) |=> owner_q == 3'd0);
  assert_owner_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc || int_rom_en) |=> $stable(owner_q));
  assert_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rom_en && (in_slot || in_win)) |-> src == (C_ROM ? SRC_SYS : SRC_NONE));
  assert_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && src == SRC_NONE) |-> rd_data == FLOAT_BYTE);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> rd_data == FLOAT_BYTE);
  assert_exp_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EXP) |-> (slot_idx != 3'd0 && in_win));
endmodule

// File: tb/slot_rom_window_dec_tb.sv
module slot_rom_window_dec_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [15:0] addr = 0;
  logic rd = 0, wr = 0, int_rom_en = 0, slot3_en = 1;
  logic [1:0] bank_sel = 0;
  logic [7:0] page_present = 8'b1101_1110;
  logic [7:0] exp_present  = 8'b1111_1010;
  logic [2:0] src, slot_idx;
  logic [15:0] rom_offset;
  logic [7:0] rd_data;
  int tests = 0, fails = 0;
  logic [2:0] m_owner = 0;

  function automatic logic [7:0] page_byte(logic [2:0] s, logic [15:0] o);
    return {s, o[4:0]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] exp_byte(logic [2:0] s, logic [15:0] o);
    return o[7:0] + {s, 5'd3} + {5'd0, o[10:8]};
  endfunction
  function automatic logic [7:0] sys_byte(logic [15:0] o);
    return o[7:0] ^ o[15:8] ^ 8'hC3;
  endfunction

  wire [7:0] card_page_data = page_byte(slot_idx, rom_offset);
  wire [7:0] card_exp_data  = exp_byte(slot_idx, rom_offset);
  wire [7:0] sys_rom_data   = sys_byte(rom_offset);

  slot_rom_window_dec dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
    .int_rom_en(int_rom_en), .slot3_en(slot3_en), .bank_sel(bank_sel),
    .page_present(page_present), .exp_present(exp_present),
    .card_page_data(card_page_data), .card_exp_data(card_exp_data),
    .sys_rom_data(sys_rom_data), .src(src), .slot_idx(slot_idx),
    .rom_offset(rom_offset), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic access(input logic [15:0] a, input bit r, input bit w, input string tag);
    logic [2:0] es; logic [7:0] ed; logic [2:0] eslot; logic [15:0] eoff;
    bit inc, islot, iwin, s3blk, sys;
    @(negedge clk);
    addr = a; rd = r; wr = w;
    #1;
    inc = a[15:12] == 4'hC;
    islot = inc && a >= 16'hC100 && a <= 16'hC7FF;
    iwin = inc && a >= 16'hC800;
    s3blk = !slot3_en && ((islot && a[10:8] == 3) || (iwin && m_owner == 3));
    sys = a >= 16'hD000 || ((islot || iwin) && (int_rom_en || s3blk));
    es = 0; eslot = 0; eoff = 0;
    if (sys) begin
      es = 3; eoff = 16'(int'(bank_sel) * 16384 + int'(a) - 32'hC000);
    end else if (islot && page_present[a[10:8]]) begin
      es = 1; eslot = a[10:8]; eoff = {8'd0, a[7:0]};
    end else if (iwin && m_owner != 0 && exp_present[m_owner]) begin
      es = 2; eslot = m_owner; eoff = {5'd0, a[10:0]};
    end
    ed = !r ? 8'hF4 : es == 1 ? page_byte(eslot, eoff) : es == 2 ? exp_byte(eslot, eoff)
       : es == 3 ? sys_byte(eoff) : 8'hF4;
    tests++;
    if (src !== es || rd_data !== ed || (es != 0 && (slot_idx !== eslot || rom_offset !== eoff))) begin
      fails++;
      $display("FAIL %s addr=%h: src=%0d data=%h slot=%0d off=%h expected src=%0d data=%h slot=%0d off=%h",
               tag, a, src, rd_data, slot_idx, rom_offset, es, ed, eslot, eoff);
    end
    if ((r || w) && !int_rom_en) begin
      if (islot) m_owner = a[10:8];
      else if (a == 16'hCFFF) m_owner = 0;
    end
    @(posedge clk);
    #1 rd = 0; wr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    access(16'hC900, 1, 0, "R10 window after reset");
    access(16'hC600, 1, 0, "R1 page");
    access(16'hC900, 1, 0, "R2 R3 owner 6");
    access(16'hCFFF, 1, 0, "R4 release uses old owner");
    access(16'hC900, 1, 0, "R4 released window");
    access(16'hC200, 0, 1, "R9 write takes ownership");
    access(16'hCA10, 1, 0, "R8 absent expansion slot 2");
    access(16'hC400, 0, 1, "R9 write");
    access(16'hCB55, 1, 0, "R2 owner by write");
    access(16'hCFFF, 0, 1, "R4 release by write");
    access(16'hCB55, 1, 0, "R4 window after write release");
    access(16'hC510, 1, 0, "R8 absent page slot 5");
    access(16'hCC00, 1, 0, "R3 slot 5 expansion");
    access(16'h0000, 1, 0, "R8 low");
    access(16'hBFFF, 1, 0, "R8 low");
    access(16'hC0FF, 1, 0, "R8 io page");
    for (int sw = 0; sw < 4; sw++) begin
      for (int b = 0; b < 4; b++) begin
        @(negedge clk);
        int_rom_en = sw[0]; slot3_en = sw[1]; bank_sel = 2'(b);
        for (int s = 1; s < 8; s++) begin
          access(16'(32'hC000 + s * 256 + s * 7), 1, 0, "R1 R5 R6 page sweep");
          access(16'(32'hC800 + s * 227), 1, 0, "R3 R5 R6 window sweep");
          access(16'(32'hC100 + ((s + 2) % 7) * 256), 0, 1, "R2 R9 write sweep");
          access(16'(32'hCFF0 - s * 64), 1, 0, "R3 R6 window after write");
          if (s % 3 == 0) begin
            access(16'hCFFF, 1, 0, "R4 release sweep");
            access(16'hCA00, 1, 0, "R4 R5 window after release");
          end
        end
        for (int k = 0; k < 24; k++)
          access(16'(32'hD000 + k * 547), 1, 0, "R7 upper rom");
        access(16'hFFFF, 1, 0, "R7 top");
      end
    end
    @(negedge clk); int_rom_en = 0; slot3_en = 0;
    access(16'hC300, 1, 0, "R6 slot3 page");
    access(16'hC9AB, 1, 0, "R6 window owner 3");
    @(negedge clk); slot3_en = 1;
    access(16'hC9AB, 1, 0, "R6 window owner 3 enabled");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule